// File: doc/BRIEF.md
# PS/2 Device-Side Link Emulator

This block plays the peripheral end of a PS/2 link. It runs from a fast system clock and reaches the shared clock and data wires only through two pull-low enables. A released wire reads high through the external pull-up. A local client hands it bytes, and the block frames each one and clocks it out, generating the link clock itself. When the host asks to talk, the block recognises the request, clocks the host's frame in, checks it, answers with the acknowledge handshake and presents the byte to the client.

Each frame on the wire is 11 bits, least significant first: a start bit of 0, eight data bits from D0 to D7, an odd parity bit and a stop bit of 1. The half period of the generated clock is a count of system clocks, `HALF_CYC`. The minimum hold-low time that marks a host request is `RTS_CYC`. The defaults give 20 µs and 100 µs at 250 MHz. Both wire inputs pass through a two-flop synchronizer before any logic uses them.

Top module: `ps2_dev_link`

## Requirements
- R1: After reset both pull-low enables are 0, and `busy`, `rx_valid` and `err` are 0.
- R2: A client byte goes out as 11 bits that the host samples on falling clock edges. Bit 0 is the start bit (0), bits 1 to 8 are D0 to D7, bit 9 makes the ones count of data plus parity odd, and bit 10 is the stop bit (1). One clock period lasts between 2·HALF_CYC and 2·HALF_CYC+6 system clocks.
- R3: `busy` is high while a frame moves. Once the frame ends, `busy` is low and the clock line is released and idle.
- R4: A `tx_valid` pulse that arrives while an earlier byte is still pending is ignored, and only one frame goes out.
- R5: If the host holds the clock low for at least RTS_CYC clocks, pulls data low and then releases the clock, the block clocks in D0 to D7, parity and stop on rising edges. It then gives one single-cycle `rx_valid` with the byte on `rx_byte`.
- R6: If the clock is held low for less than RTS_CYC before release, no clock is generated and `busy` stays low.
- R7: After the host's stop bit, the block pulls data low while the clock is high, and only then pulls the clock low.
- R8: A received frame with wrong parity or a stop bit of 0 gives a single-cycle `err` and no `rx_valid`.
- R9: If the host holds the clock low for more than HALF_CYC clocks while the block is sending, the block releases both lines, drops `busy` and pulses `err`. It keeps the byte and sends it whole after the next idle.
- R10: A byte that the client offers while a host frame is being received is sent once that reception ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tx_byte | input | 8 | Byte to send to the host |
| tx_valid | input | 1 | One-cycle strobe that loads `tx_byte` |
| rx_byte | output | 8 | Last byte received from the host |
| rx_valid | output | 1 | One-cycle strobe for a good received byte |
| busy | output | 1 | High while a frame is in progress |
| err | output | 1 | One-cycle pulse on abort or on a bad received frame |
| kb_clk_in | input | 1 | Level of the shared clock wire |
| kb_dat_in | input | 1 | Level of the shared data wire |
| kb_clk_low | output | 1 | 1 pulls the clock wire low, 0 releases it |
| kb_dat_low | output | 1 | 1 pulls the data wire low, 0 releases it |

## Verification
Two functions can land in the same cycle. The host can begin its hold-low request while the block is in the middle of sending. The client can also strobe a new byte while a host frame is being clocked in. The bench provokes the first by pulling the clock low just after a rising edge of a device frame. It then expects exactly one error pulse, both enables released, a correct reception of the host's byte, and finally a complete resend of the interrupted byte. For the second, a client strobe is issued mid-reception, and the bench checks that the host byte arrives intact and that the client byte follows as a full frame.

// File: rtl/ps2_dev_link.sv
module ps2_dev_link #(
  parameter int HALF_CYC = 5000,
  parameter int RTS_CYC  = 25000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] tx_byte,
  input  logic       tx_valid,
  output logic [7:0] rx_byte,
  output logic       rx_valid,
  output logic       busy,
  output logic       err,
  input  logic       kb_clk_in,
  input  logic       kb_dat_in,
  output logic       kb_clk_low,
  output logic       kb_dat_low
);
  localparam int TW = $clog2(HALF_CYC + 1);
  localparam int LW = $clog2(RTS_CYC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_HREQ, S_TXH, S_TXL, S_RXH, S_RXL, S_ACKD, S_ACKC, S_DONE
  } st_t;

  st_t         st;
  logic [1:0]  cs, ds;
  logic [TW-1:0] tmr;
  logic [LW-1:0] lo;
  logic [3:0]  bitn;
  logic [10:0] sh;
  logic [7:0]  pend;
  logic        pv, dir_rx;

  wire clk_s     = cs[1];
  wire dat_s     = ds[1];
  wire half_done = (tmr == TW'(HALF_CYC - 1));
  wire frame_ok  = (^sh[9:1]) & sh[10];

  assign busy = !(st == S_IDLE || st == S_HREQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs <= 2'b11;
      ds <= 2'b11;
    end else begin
      cs <= {cs[0], kb_clk_in};
      ds <= {ds[0], kb_dat_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clk_s || kb_clk_low) lo <= '0;
    else if (lo != LW'(RTS_CYC)) lo <= lo + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      tmr <= '0;
      bitn <= '0;
      sh <= '0;
      pend <= '0;
      pv <= 1'b0;
      dir_rx <= 1'b0;
      rx_byte <= '0;
      rx_valid <= 1'b0;
      err <= 1'b0;
      kb_clk_low <= 1'b0;
      kb_dat_low <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      err <= 1'b0;
      tmr <= half_done ? '0 : tmr + 1'b1;
      case (st)
        S_IDLE: begin
          tmr <= '0;
          if (!clk_s) st <= S_HREQ;
          else if (pv) begin
            sh <= {1'b1, ~^pend, pend, 1'b0};
            bitn <= '0;
            dir_rx <= 1'b0;
            kb_dat_low <= 1'b1;
            st <= S_TXH;
          end
        end
        S_HREQ: begin
          if (clk_s) begin
            tmr <= '0;
            if (lo >= LW'(RTS_CYC) && !dat_s) begin
              bitn <= '0;
              dir_rx <= 1'b1;
              st <= S_RXH;
            end else st <= S_IDLE;
          end
        end
        S_TXH: begin
          if (!clk_s) begin
            tmr <= '0;
            if (lo >= LW'(HALF_CYC)) begin
              kb_clk_low <= 1'b0;
              kb_dat_low <= 1'b0;
              err <= 1'b1;
              st <= S_IDLE;
            end
          end else if (half_done) begin
            kb_clk_low <= 1'b1;
            st <= S_TXL;
          end
        end
        S_TXL: begin
          if (half_done) begin
            kb_clk_low <= 1'b0;
            sh <= {1'b0, sh[10:1]};
            bitn <= bitn + 1'b1;
            if (bitn == 4'd10) begin
              kb_dat_low <= 1'b0;
              st <= S_DONE;
            end else begin
              kb_dat_low <= ~sh[1];
              st <= S_TXH;
            end
          end
        end
        S_RXH: begin
          if (half_done) begin
            kb_clk_low <= 1'b1;
            st <= S_RXL;
          end
        end
        S_RXL: begin
          if (half_done) begin
            kb_clk_low <= 1'b0;
            sh <= {dat_s, sh[10:1]};
            bitn <= bitn + 1'b1;
            if (bitn == 4'd9) begin
              kb_dat_low <= 1'b1;
              st <= S_ACKD;
            end else st <= S_RXH;
          end
        end
        S_ACKD: begin
          if (half_done) begin
            kb_clk_low <= 1'b1;
            st <= S_ACKC;
          end
        end
        S_ACKC: begin
          if (half_done) begin
            kb_clk_low <= 1'b0;
            kb_dat_low <= 1'b0;
            st <= S_DONE;
          end
        end
        S_DONE: begin
          if (half_done) begin
            st <= S_IDLE;
            if (!dir_rx) pv <= 1'b0;
            else if (frame_ok) begin
              rx_valid <= 1'b1;
              rx_byte <= sh[8:1];
            end else err <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (tx_valid && !pv) begin
        pend <= tx_byte;
        pv <= 1'b1;
      end
    end
  end

  p_idle_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!kb_clk_low && !kb_dat_low));

  p_rv_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_err_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  p_bad_no_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !err);

  p_ack_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACKC) |-> kb_dat_low);

  p_pend_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $past(pv)) |-> $stable(pend));
endmodule

// File: tb/ps2_dev_link_tb_top.sv
`timescale 1ns/1ps
module ps2_dev_link_tb_top;
  localparam int H = 20;
  localparam int R = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] tx_byte = '0;
  logic tx_valid = 1'b0;
  logic h_clk_low = 1'b0, h_dat_low = 1'b0;
  wire [7:0] rx_byte;
  wire rx_valid, busy, err, kb_clk_low, kb_dat_low;
  wire kclk = ~(kb_clk_low | h_clk_low);
  wire kdat = ~(kb_dat_low | h_dat_low);

  ps2_dev_link #(.HALF_CYC(H), .RTS_CYC(R)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_byte(tx_byte), .tx_valid(tx_valid),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .busy(busy), .err(err),
    .kb_clk_in(kclk), .kb_dat_in(kdat),
    .kb_clk_low(kb_clk_low), .kb_dat_low(kb_dat_low));

  int vec = 0, bad = 0, rv_cnt = 0, err_cnt = 0, fall_cnt = 0;
  logic [7:0] last_rx = '0;

  always @(negedge clk) begin
    if (rx_valid) begin rv_cnt++; last_rx = rx_byte; end
    if (err) err_cnt++;
  end
  always @(negedge kclk) fall_cnt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic client_send(input logic [7:0] b);
    @(negedge clk); tx_byte = b; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic host_recv(output logic [10:0] f, output int per);
    time t0 = 0;
    per = 0;
    for (int i = 0; i < 11; i++) begin
      @(negedge kclk); #1;
      f[i] = kdat;
      if (i == 0) t0 = $time;
      if (i == 1) per = int'(($time - t0) / 4);
    end
  endtask

  task automatic check_frame(input string tag, input logic [10:0] f, input logic [7:0] b);
    chk({tag, " start bit"}, 32'(f[0]), 0);
    chk({tag, " data bits"}, 32'(f[8:1]), 32'(b));
    chk({tag, " odd parity"}, 32'(f[9]), 32'(~^b));
    chk({tag, " stop bit"}, 32'(f[10]), 1);
  endtask

  task automatic host_send(input logic [7:0] b, input logic badpar, input logic badstop);
    logic [9:0] bits;
    bits = {~badstop, (~^b) ^ badpar, b};
    h_clk_low = 1'b1; cycles(R + 20);
    h_dat_low = 1'b1; cycles(4);
    h_clk_low = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge kclk); #1;
      if (i == 0) chk("R5 busy during reception", 32'(busy), 1);
      h_dat_low = ~bits[i];
    end
    @(posedge kclk); #1;
    h_dat_low = 1'b0; #1;
    chk("R7 data low while clock high", 32'({kdat, kclk}), 32'b01);
    @(negedge kclk); #1;
    chk("R7 data held low at clock fall", 32'(kdat), 0);
  endtask

  task automatic t_reset;
    chk("R1 clock enable", 32'(kb_clk_low), 0);
    chk("R1 data enable", 32'(kb_dat_low), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 rx_valid", 32'(rx_valid), 0);
    chk("R1 err", 32'(err), 0);
  endtask

  task automatic t_send_double;
    logic [10:0] f; int per; int f0;
    @(negedge clk); tx_byte = 8'hA5; tx_valid = 1'b1;
    @(negedge clk); tx_byte = 8'h3C;
    @(negedge clk); tx_valid = 1'b0;
    host_recv(f, per);
    check_frame("R2 A5", f, 8'hA5);
    chk("R2 period in range", 32'(per >= 2*H && per <= 2*H + 6), 1);
    chk("R3 busy during frame", 32'(busy), 1);
    cycles(3*H);
    chk("R3 busy after frame", 32'(busy), 0);
    chk("R3 clock released", 32'({kclk, kb_clk_low}), 32'b10);
    f0 = fall_cnt;
    cycles(8*H);
    chk("R4 second strobe ignored", 32'(fall_cnt - f0), 0);
  endtask

  task automatic t_send(input logic [7:0] b);
    logic [10:0] f; int per;
    client_send(b);
    host_recv(f, per);
    check_frame("R2 pattern", f, b);
    cycles(3*H);
  endtask

  task automatic t_host_rx(input logic [7:0] b);
    int r0, e0;
    r0 = rv_cnt; e0 = err_cnt;
    host_send(b, 1'b0, 1'b0);
    cycles(3*H);
    chk("R5 one rx_valid", 32'(rv_cnt - r0), 1);
    chk("R5 received byte", 32'(last_rx), 32'(b));
    chk("R5 no err", 32'(err_cnt - e0), 0);
    chk("R3 busy low after reception", 32'(busy), 0);
  endtask

  task automatic t_short;
    int f0;
    f0 = fall_cnt;
    h_dat_low = 1'b1; h_clk_low = 1'b1;
    cycles(R/2);
    h_clk_low = 1'b0; cycles(2);
    h_dat_low = 1'b0;
    f0 = fall_cnt;
    cycles(6*H);
    chk("R6 no clock after short hold", 32'(fall_cnt - f0), 0);
    chk("R6 busy stays low", 32'(busy), 0);
  endtask

  task automatic t_bad(input logic bp, input logic bs);
    int r0, e0;
    r0 = rv_cnt; e0 = err_cnt;
    host_send(8'h5A, bp, bs);
    cycles(3*H);
    chk("R8 err pulse", 32'(err_cnt - e0), 1);
    chk("R8 no rx_valid", 32'(rv_cnt - r0), 0);
  endtask

  task automatic t_abort;
    logic [10:0] f; int per; int e0, r0;
    client_send(8'h96);
    repeat (3) @(negedge kclk);
    @(posedge kclk);
    cycles(4);
    e0 = err_cnt; r0 = rv_cnt;
    h_clk_low = 1'b1;
    cycles(H + 8);
    chk("R9 err on abort", 32'(err_cnt - e0), 1);
    chk("R9 lines released", 32'({kb_clk_low, kb_dat_low}), 0);
    chk("R9 busy dropped", 32'(busy), 0);
    host_send(8'h81, 1'b0, 1'b0);
    host_recv(f, per);
    check_frame("R9 retried byte", f, 8'h96);
    cycles(3*H);
    chk("R5 host byte during collision", 32'(last_rx), 32'h81);
    chk("R9 only one err", 32'(err_cnt - e0), 1);
  endtask

  task automatic t_collide;
    logic [10:0] f; int per;
    fork
      host_send(8'h3E, 1'b0, 1'b0);
      begin cycles(R + 24 + 6*H); client_send(8'h77); end
    join
    host_recv(f, per);
    check_frame("R10 queued byte", f, 8'h77);
    chk("R10 host byte intact", 32'(last_rx), 32'h3E);
    cycles(3*H);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vec++; bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    cycles(5);
    rst_n = 1'b1;
    cycles(3);
    t_reset();
    t_send_double();
    t_send(8'h07);
    t_send(8'h00);
    t_host_rx(8'hC3);
    t_short();
    t_bad(1'b1, 1'b0);
    t_bad(1'b0, 1'b1);
    t_abort();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule